// File: doc/BRIEF.md
# Per-Symbol Signed Extreme Tracker

This block watches a stream of signed samples, one per clock, and finds the largest and the smallest sample in each symbol period. A single-cycle strobe from outside marks where one period ends and the next begins. On the strobe cycle the block does two things at the same clock edge. It freezes the extremes of the period that just closed into result registers. It also restarts both trackers from the sample present on that cycle. No sample is dropped, and no value from the old period carries into the new one.

Results appear one clock after the strobe, together with a one-cycle valid pulse. They then hold until the next strobe. The first period after reset begins at reset, not at a strobe. A sticky warm-up flag therefore marks the results of that period, so that downstream logic can discard them. All paths are registered in a single clock domain, and the sample width is a parameter.

Top module: `symbol_extreme_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, the results `max_o` and `min_o` clear to zero, `valid_o` clears to 0 and `warmup_o` sets to 1. The hidden running maximum is set to the most negative code and the running minimum to the most positive code.
- R2: On an edge where `strobe_i` is low, the running maximum becomes the larger of itself and `sample_i`, and the running minimum becomes the smaller. Both comparisons treat the values as two's-complement signed numbers of width `W` (default 12).
- R3: On an edge where `strobe_i` is high, `max_o` and `min_o` load the running extremes as they stood before that edge. The sample present on the strobe cycle is excluded from them.
- R4: On an edge where `strobe_i` is high, both running extremes load `sample_i` directly, so the strobe sample is the first member of the new period.
- R5: `max_o` and `min_o` change only on the edge that follows a strobe. On every other edge they hold their value.
- R6: `valid_o` is high for exactly the cycle after each strobe. Strobes on consecutive cycles give valid pulses on consecutive cycles.
- R7: All outputs are registered. A change on `sample_i` or `strobe_i` has no effect on any output before the next rising edge of `clk`.
- R8: `warmup_o` stays high from reset through the valid pulse of the first strobe. It falls together with the second valid pulse and stays low until the next reset.
- R9: A strobe on the first cycle after reset yields `max_o` equal to the most negative code (0x800 at W=12) and `min_o` equal to the most positive code (0x7FF at W=12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | W | Signed sample, one per clock |
| strobe_i | input | 1 | One-cycle symbol boundary marker |
| max_o | output | W | Largest sample of the last completed period |
| min_o | output | W | Smallest sample of the last completed period |
| valid_o | output | 1 | One-cycle pulse when new results are shown |
| warmup_o | output | 1 | High while the shown results come from the period that began at reset |

## Verification
The bound checker checks the following on every cycle:
- the results hold when no strobe occurred;
- the results equal the trackers' pre-edge contents after a strobe;
- the trackers reload with the strobe sample;
- the trackers never move away from the running extreme;
- the valid pulse follows the strobe exactly;
- the warm-up flag never rises again except through reset.

Other properties need the bench's directed scenarios:
- the exact extreme values of given signed sample sequences, including the full-scale codes;
- the reset-valued results of a strobe right after reset;
- the warm-up flag falling with the second pulse;
- the absence of any combinational path from the inputs to the outputs.

// File: rtl/extreme_tracker_pkg.sv
package extreme_tracker_pkg;
  typedef enum logic { TRK_MAX = 1'b0, TRK_MIN = 1'b1 } trk_kind_e;

  // Decide whether the new sample replaces the held extreme.
  function automatic logic take_new(trk_kind_e kind, logic new_gt_old, logic new_lt_old);
    return (kind == TRK_MAX) ? new_gt_old : new_lt_old;
  endfunction
endpackage

// File: rtl/extreme_tracker_cell.sv
module extreme_tracker_cell
  import extreme_tracker_pkg::*;
#(
  parameter int        W    = 12,
  parameter trk_kind_e KIND = TRK_MAX
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sample,
  input  logic         restart,
  output logic [W-1:0] run_q
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] reset_val;
  logic         new_gt_old;
  logic         new_lt_old;
  logic         replace;
  logic [W-1:0] next_val;

  generate
    if (KIND == TRK_MAX) begin : g_max
      assign reset_val = MOST_NEG;
    end else begin : g_min
      assign reset_val = MOST_POS;
    end
  endgenerate

  assign new_gt_old = $signed(sample) > $signed(run_q);
  assign new_lt_old = $signed(sample) < $signed(run_q);
  assign replace    = take_new(KIND, new_gt_old, new_lt_old);
  assign next_val   = (restart || replace) ? sample : run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= reset_val;
    else     run_q <= next_val;
  end
endmodule

// File: rtl/extreme_result_hold.sv
module extreme_result_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic         fresh_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      lo_q    <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= capture;
      if (capture) begin
        hi_q <= hi_in;
        lo_q <= lo_in;
      end
    end
  end
endmodule

// File: rtl/extreme_period_flags.sv
module extreme_period_flags (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  output logic warmup_q
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      warmup_q <= 1'b1;
    end else if (boundary) begin
      seen_q   <= 1'b1;
      warmup_q <= warmup_q & ~seen_q;
    end
  end
endmodule

// File: rtl/symbol_extreme_tracker.sv
module symbol_extreme_tracker
  import extreme_tracker_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sample_i,
  input  logic         strobe_i,
  output logic [W-1:0] max_o,
  output logic [W-1:0] min_o,
  output logic         valid_o,
  output logic         warmup_o
);
  // Named internal events, visible to the bound checker.
  logic         boundary;
  logic [W-1:0] run_max;
  logic [W-1:0] run_min;

  assign boundary = strobe_i;

  extreme_tracker_cell #(.W(W), .KIND(TRK_MAX)) u_max_cell (
    .clk(clk), .rst(rst), .sample(sample_i), .restart(boundary), .run_q(run_max)
  );

  extreme_tracker_cell #(.W(W), .KIND(TRK_MIN)) u_min_cell (
    .clk(clk), .rst(rst), .sample(sample_i), .restart(boundary), .run_q(run_min)
  );

  extreme_result_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .capture(boundary),
    .hi_in(run_max), .lo_in(run_min),
    .hi_q(max_o), .lo_q(min_o), .fresh_q(valid_o)
  );

  extreme_period_flags u_flags (
    .clk(clk), .rst(rst), .boundary(boundary), .warmup_q(warmup_o)
  );
endmodule

// File: rtl/symbol_extreme_tracker_checker.sv
module symbol_extreme_tracker_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] sample_i,
  input logic         strobe_i,
  input logic [W-1:0] max_o,
  input logic [W-1:0] min_o,
  input logic         valid_o,
  input logic         warmup_o,
  input logic [W-1:0] run_max,
  input logic [W-1:0] run_min
);
  // High once the previous edge was outside reset, so $past is meaningful.
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    armed_q && !$past(strobe_i) |-> $stable(max_o) && $stable(min_o));

  p_capture_prior_r3: assert property (@(posedge clk) disable iff (rst)
    armed_q && $past(strobe_i) |-> max_o == $past(run_max) && min_o == $past(run_min));

  p_restart_sample_r4: assert property (@(posedge clk) disable iff (rst)
    armed_q && $past(strobe_i) |-> run_max == $past(sample_i) && run_min == $past(sample_i));

  p_max_grows_r2: assert property (@(posedge clk) disable iff (rst)
    armed_q && !$past(strobe_i) |->
      $signed(run_max) >= $signed($past(run_max)) && $signed(run_max) >= $signed($past(sample_i)));

  p_min_shrinks_r2: assert property (@(posedge clk) disable iff (rst)
    armed_q && !$past(strobe_i) |->
      $signed(run_min) <= $signed($past(run_min)) && $signed(run_min) <= $signed($past(sample_i)));

  p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> valid_o == $past(strobe_i));

  p_warmup_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    armed_q && !$past(warmup_o) |-> !warmup_o);

  p_warmup_falls_r8: assert property (@(posedge clk) disable iff (rst)
    armed_q && $fell(warmup_o) |-> valid_o);
endmodule

bind symbol_extreme_tracker symbol_extreme_tracker_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sample_i(sample_i), .strobe_i(strobe_i),
  .max_o(max_o), .min_o(min_o), .valid_o(valid_o), .warmup_o(warmup_o),
  .run_max(run_max), .run_min(run_min)
);

// File: tb/symbol_extreme_tracker_bench.sv
module symbol_extreme_tracker_bench;
  localparam int W      = 12;
  localparam int HALF   = 10;   // 20 ns period, 50 MHz
  localparam int NEG_LIM = -(1 <<< (W-1));
  localparam int POS_LIM = (1 <<< (W-1)) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] sample_i = '0;
  logic         strobe_i = 1'b0;
  logic [W-1:0] max_o, min_o;
  logic         valid_o, warmup_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bench-side reference of the period extremes.
  int ref_hi, ref_lo, exp_hi, exp_lo;

  symbol_extreme_tracker #(.W(W)) u_symbol_extreme_tracker (
    .clk(clk), .rst(rst), .sample_i(sample_i), .strobe_i(strobe_i),
    .max_o(max_o), .min_o(min_o), .valid_o(valid_o), .warmup_o(warmup_o)
  );

  always #HALF clk = ~clk;

  function automatic int as_int(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, update the reference, return at the next falling edge.
  task automatic step(input int s, input bit stb);
    sample_i = s[W-1:0];
    strobe_i = stb;
    if (stb) begin
      exp_hi = ref_hi; exp_lo = ref_lo;
      ref_hi = s; ref_lo = s;
    end else begin
      if (s > ref_hi) ref_hi = s;
      if (s < ref_lo) ref_lo = s;
    end
    @(negedge clk);
    strobe_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    strobe_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ref_hi = NEG_LIM; ref_lo = POS_LIM;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(max_o == '0, "R1", "max after reset", as_int(max_o), 0);
    check(min_o == '0, "R1", "min after reset", as_int(min_o), 0);
    check(valid_o == 1'b0, "R1", "valid after reset", valid_o, 0);
    check(warmup_o == 1'b1, "R1", "warmup after reset", warmup_o, 1);
  endtask

  task automatic t_first_strobe();
    do_reset();
    step(33, 1'b1);
    check(as_int(max_o) == NEG_LIM, "R9", "max from reset", as_int(max_o), NEG_LIM);
    check(as_int(min_o) == POS_LIM, "R9", "min from reset", as_int(min_o), POS_LIM);
    check(valid_o == 1'b1, "R6", "valid after first strobe", valid_o, 1);
    check(warmup_o == 1'b1, "R8", "warmup during first pulse", warmup_o, 1);
    step(0, 1'b0);
    check(valid_o == 1'b0, "R6", "valid single cycle", valid_o, 0);
  endtask

  task automatic t_mixed_period();
    step(5, 1'b0); step(-3, 1'b0); step(100, 1'b0); step(-7, 1'b0);
    step(42, 1'b1);
    check(as_int(max_o) == 100, "R3", "mixed period max", as_int(max_o), 100);
    check(as_int(min_o) == -7, "R3", "mixed period min", as_int(min_o), -7);
    check(warmup_o == 1'b0, "R8", "warmup clears on second pulse", warmup_o, 0);
    step(10, 1'b0);
    step(0, 1'b1);
    check(as_int(max_o) == 42, "R4", "strobe sample starts next max", as_int(max_o), 42);
    check(as_int(min_o) == 10, "R4", "strobe sample starts next min", as_int(min_o), 10);
  endtask

  task automatic t_back_to_back();
    step(7, 1'b1);
    check(valid_o == 1'b1, "R6", "first of adjacent pulses", valid_o, 1);
    step(9, 1'b1);
    check(valid_o == 1'b1, "R6", "second of adjacent pulses", valid_o, 1);
    check(as_int(max_o) == 7 && as_int(min_o) == 7, "R4", "single-sample period", as_int(max_o), 7);
    step(1, 1'b0);
    check(valid_o == 1'b0, "R6", "pulse train ends", valid_o, 0);
    check(warmup_o == 1'b0, "R8", "warmup stays low", warmup_o, 0);
  endtask

  task automatic t_full_scale();
    step(-1, 1'b1);
    step(POS_LIM, 1'b0); step(NEG_LIM, 1'b0); step(0, 1'b0); step(POS_LIM, 1'b0);
    step(-500, 1'b1);
    check(as_int(max_o) == POS_LIM, "R2", "signed max full scale", as_int(max_o), POS_LIM);
    check(as_int(min_o) == NEG_LIM, "R2", "signed min full scale", as_int(min_o), NEG_LIM);
    check(as_int(max_o) == exp_hi && as_int(min_o) == exp_lo, "R2", "reference agrees", as_int(max_o), exp_hi);
  endtask

  task automatic t_hold();
    int hold_hi, hold_lo;
    hold_hi = as_int(max_o); hold_lo = as_int(min_o);
    for (int i = 0; i < 6; i++) begin
      step((i % 2 == 0) ? 1500 + i : -1500 - i, 1'b0);
      check(as_int(max_o) == hold_hi, "R5", "max holds without strobe", as_int(max_o), hold_hi);
      check(as_int(min_o) == hold_lo, "R5", "min holds without strobe", as_int(min_o), hold_lo);
    end
    step(3, 1'b1);
    check(as_int(max_o) == exp_hi && as_int(min_o) == exp_lo, "R3", "hold period results", as_int(min_o), exp_lo);
  endtask

  task automatic t_latency();
    int before_hi;
    step(-20, 1'b0);
    before_hi = as_int(max_o);
    sample_i = 12'sd900;
    strobe_i = 1'b1;
    #(HALF/2);
    check(valid_o == 1'b0, "R7", "valid not combinational", valid_o, 0);
    check(as_int(max_o) == before_hi, "R7", "max not combinational", as_int(max_o), before_hi);
    exp_hi = ref_hi; exp_lo = ref_lo; ref_hi = 900; ref_lo = 900;
    @(negedge clk);
    strobe_i = 1'b0;
    check(valid_o == 1'b1 && as_int(max_o) == exp_hi, "R7", "update after edge", as_int(max_o), exp_hi);
  endtask

  task automatic t_reset_midstream();
    step(77, 1'b0);
    do_reset();
    check(max_o == '0 && min_o == '0, "R1", "results cleared mid-stream", as_int(max_o), 0);
    check(warmup_o == 1'b1, "R1", "warmup re-armed", warmup_o, 1);
    step(4, 1'b0);
    step(8, 1'b1);
    check(as_int(max_o) == 4 && as_int(min_o) == 4, "R2", "first period after reset", as_int(max_o), 4);
    check(warmup_o == 1'b1, "R8", "warmup on first pulse again", warmup_o, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_first_strobe();
    t_mixed_period();
    t_back_to_back();
    t_full_scale();
    t_hold();
    t_latency();
    t_reset_midstream();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule